// File: doc/BRIEF.md
# Vector Structure Load De-interleaver

This block runs one multiple-structure vector load. It reads consecutive memory elements, one request per element, and writes each element into a lane of one of up to four consecutive 128-bit vector registers. A single three-level loop covers both cases. In the interleaved case, N-element structures are spread across N registers. In the other case, one-element structures fill M registers one after another. The caller gives a base address, a 2-bit element size, a full-width flag, the first register number, the structure element count N and the register count M. The block reports completion with a one-cycle done pulse.

The sequencer has five states. `ST_IDLE` waits for a start command and latches it. `ST_REQ` holds a read request until the memory port accepts it (transition REQ to WAIT on ready). `ST_WAIT` waits for the response and captures the element (transition WAIT to WRITE on response valid). `ST_WRITE` issues one lane write and advances the loop counters and the address. From `ST_WRITE` the machine goes back to `ST_REQ`, or to `ST_DONE` after the final element. `ST_DONE` raises done for one cycle and then returns to `ST_IDLE`. Only one read is outstanding at any time.

Top module: `vstruct_ld_seq`

## Requirements
- R1: The size code sets the element width: 0 is 1 byte, 1 is 2 bytes, 2 is 4 bytes, 3 is 8 bytes. `wr_size_o` repeats the code. `wr_data_o` carries the element in its low 8<<size bits, and all higher bits are zero even when the response has other bytes there.
- R2: Each register receives 8, 4, 2 or 1 lanes for size codes 0 to 3 when `qfull_i` is 0, and twice that number when `qfull_i` is 1.
- R3: The repeat count is 1 when N equals M and M otherwise, and the inner count is N. Elements are handled with the repeat index i outermost, the lane j next and the structure element k innermost. Element (i,j,k) is written to register first+i+k, lane j.
- R4: With N=M, consecutive elements go round-robin over the N registers. With N=1 and M>1, each register gets all its lanes before the next register starts.
- R5: Read addresses start at the base and increase by exactly one element size per request, with one request per element and no gaps.
- R6: Register numbers wrap modulo 32. For example, first=30 with three registers writes 30, 31 and 0.
- R7: Every lane write raises `wr_clr_hi_o` when `qfull_i` was 0, telling the register file to clear bits 127:64 of that register. The flag is low when `qfull_i` was 1.
- R8: A start that arrives while `busy_o` is high is ignored. The running operation and its outputs are unchanged, and no further operation follows.
- R9: `done_o` is high for exactly one cycle, the cycle after the final lane write. `busy_o` is low from the next cycle on.
- R10: A read request, once raised, stays valid with a stable address until `rd_req_ready_i` accepts it.
- R11: After reset, `busy_o`, `rd_req_valid_o`, `wr_en_o` and `done_o` are low.
- R12: Each lane write follows exactly one accepted response, and no write occurs without one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Start command, taken only when idle |
| base_addr_i | input | ADDR_W | Byte address of the first element |
| esize_i | input | 2 | Element size code |
| qfull_i | input | 1 | 1 for 128-bit registers, 0 for 64-bit |
| first_reg_i | input | REG_W | First destination register |
| nelem_i | input | CNT_W | Elements per structure N (1..4) |
| nregs_i | input | CNT_W | Registers in the group M (1..4) |
| busy_o | output | 1 | Operation in progress |
| rd_req_valid_o | output | 1 | Read request valid |
| rd_req_ready_i | input | 1 | Read request accepted |
| rd_addr_o | output | ADDR_W | Read byte address |
| rd_size_o | output | 2 | Read size code |
| rd_rsp_valid_i | input | 1 | Read response valid |
| rd_rsp_data_i | input | 64 | Response bytes, element in the low bits |
| wr_en_o | output | 1 | Lane write strobe |
| wr_reg_o | output | REG_W | Destination register |
| wr_lane_o | output | 4 | Destination lane index |
| wr_size_o | output | 2 | Lane size code |
| wr_data_o | output | 64 | Element, zero-extended |
| wr_clr_hi_o | output | 1 | Clear upper 64 bits of the destination |
| done_o | output | 1 | Completion pulse |

## Verification
The bench covers several cases that a faulty sequencer would get wrong. A swapped loop nest would make N=1,M>1 groups round-robin, and an N=M group would then fill one register at a time. A register sum without truncation would send the first=30 groups to registers 32 and up instead of 0. Response bytes above the element width are kept non-zero, so an unmasked write shows up as wrong data. Read-ready stalls check that the address holds and that no element is skipped. A start pulse in the middle of an operation checks that the operation neither restarts nor repeats.

// File: rtl/vld_pkg.sv
package vld_pkg;

    localparam int ELEM_W = 64;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_REQ,
        ST_WAIT,
        ST_WRITE,
        ST_DONE
    } vld_state_e;

    // lanes in one register: 8 >> size for a 64-bit half, doubled when full
    function automatic logic [4:0] lanes_per_reg(input logic [1:0] sz, input logic full);
        logic [4:0] half;
        half = 5'd8 >> sz;
        return full ? {half[3:0], 1'b0} : half;
    endfunction

    function automatic logic [ELEM_W-1:0] elem_mask(input logic [1:0] sz);
        logic [ELEM_W-1:0] m;
        case (sz)
            2'd0:    m = 64'h0000_0000_0000_00FF;
            2'd1:    m = 64'h0000_0000_0000_FFFF;
            2'd2:    m = 64'h0000_0000_FFFF_FFFF;
            default: m = 64'hFFFF_FFFF_FFFF_FFFF;
        endcase
        return m;
    endfunction

endpackage

// File: rtl/vld_addr_gen.sv
module vld_addr_gen #(
    parameter int ADDR_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load_i,
    input  logic [ADDR_W-1:0] base_i,
    input  logic [1:0]        size_i,
    input  logic              step_i,
    output logic [ADDR_W-1:0] addr_o
);
    logic [ADDR_W-1:0] addr_q;
    logic [1:0]        size_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            addr_q <= '0;
            size_q <= '0;
        end else if (load_i) begin
            addr_q <= base_i;
            size_q <= size_i;
        end else if (step_i) begin
            addr_q <= addr_q + (ADDR_W'(1) << size_q);
        end
    end

    assign addr_o = addr_q;

    // R5: a step never leaves the address unchanged
    a_r5_addr_moves: assert property (@(posedge clk) disable iff (!rst_n)
        step_i && !load_i |=> addr_o != $past(addr_o));
endmodule

// File: rtl/vld_loop_idx.sv
module vld_loop_idx #(
    parameter int CNT_W  = 3,
    parameter int LANE_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load_i,
    input  logic              step_i,
    input  logic [CNT_W-1:0]  rpt_i,
    input  logic [CNT_W-1:0]  selem_i,
    input  logic [LANE_W:0]   lanes_i,
    output logic [CNT_W-1:0]  rep_o,
    output logic [CNT_W-1:0]  elem_o,
    output logic [LANE_W-1:0] lane_o,
    output logic              last_o
);
    logic [CNT_W-1:0]  rpt_q, selem_q, i_q, k_q;
    logic [LANE_W:0]   lanes_q;
    logic [LANE_W-1:0] j_q;
    logic              k_end, j_end, i_end;

    assign k_end  = (k_q == selem_q - CNT_W'(1));
    assign j_end  = ({1'b0, j_q} == lanes_q - (LANE_W+1)'(1));
    assign i_end  = (i_q == rpt_q - CNT_W'(1));
    assign last_o = i_end && j_end && k_end;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rpt_q   <= CNT_W'(1);
            selem_q <= CNT_W'(1);
            lanes_q <= (LANE_W+1)'(1);
            i_q     <= '0;
            j_q     <= '0;
            k_q     <= '0;
        end else if (load_i) begin
            rpt_q   <= rpt_i;
            selem_q <= selem_i;
            lanes_q <= lanes_i;
            i_q     <= '0;
            j_q     <= '0;
            k_q     <= '0;
        end else if (step_i) begin
            if (!k_end) begin
                k_q <= k_q + CNT_W'(1);
            end else begin
                k_q <= '0;
                if (!j_end) begin
                    j_q <= j_q + LANE_W'(1);
                end else begin
                    j_q <= '0;
                    i_q <= i_end ? '0 : i_q + CNT_W'(1);
                end
            end
        end
    end

    assign rep_o  = i_q;
    assign elem_o = k_q;
    assign lane_o = j_q;

    // R3: indices stay inside the limits latched at start
    a_r3_index_range: assert property (@(posedge clk) disable iff (!rst_n)
        k_q < selem_q && {1'b0, j_q} < lanes_q && i_q < rpt_q);
endmodule

// File: rtl/vstruct_ld_seq.sv
module vstruct_ld_seq
    import vld_pkg::*;
#(
    parameter int ADDR_W    = 32,
    parameter int NUM_VREGS = 32,
    parameter int CNT_W     = 3,
    localparam int REG_W    = $clog2(NUM_VREGS),
    localparam int LANE_W   = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic [ADDR_W-1:0] base_addr_i,
    input  logic [1:0]        esize_i,
    input  logic              qfull_i,
    input  logic [REG_W-1:0]  first_reg_i,
    input  logic [CNT_W-1:0]  nelem_i,
    input  logic [CNT_W-1:0]  nregs_i,
    output logic              busy_o,
    output logic              rd_req_valid_o,
    input  logic              rd_req_ready_i,
    output logic [ADDR_W-1:0] rd_addr_o,
    output logic [1:0]        rd_size_o,
    input  logic              rd_rsp_valid_i,
    input  logic [63:0]       rd_rsp_data_i,
    output logic              wr_en_o,
    output logic [REG_W-1:0]  wr_reg_o,
    output logic [3:0]        wr_lane_o,
    output logic [1:0]        wr_size_o,
    output logic [63:0]       wr_data_o,
    output logic              wr_clr_hi_o,
    output logic              done_o
);
    vld_state_e state_q, state_d;

    logic              accept, step, last;
    logic [1:0]        size_q;
    logic              full_q;
    logic [REG_W-1:0]  first_q;
    logic [ELEM_W-1:0] data_q;
    logic [CNT_W-1:0]  rpt, rep, elem;
    logic [LANE_W-1:0] lane;
    logic [ADDR_W-1:0] addr;

    assign accept = (state_q == ST_IDLE) && start_i;
    assign step   = (state_q == ST_WRITE);
    assign rpt    = (nelem_i == nregs_i) ? CNT_W'(1) : nregs_i;

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  if (start_i)        state_d = ST_REQ;
            ST_REQ:   if (rd_req_ready_i) state_d = ST_WAIT;
            ST_WAIT:  if (rd_rsp_valid_i) state_d = ST_WRITE;
            ST_WRITE: state_d = last ? ST_DONE : ST_REQ;
            ST_DONE:  state_d = ST_IDLE;
            default:  state_d = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // command and element capture
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            size_q  <= '0;
            full_q  <= 1'b0;
            first_q <= '0;
            data_q  <= '0;
        end else begin
            if (accept) begin
                size_q  <= esize_i;
                full_q  <= qfull_i;
                first_q <= first_reg_i;
            end
            if (state_q == ST_WAIT && rd_rsp_valid_i)
                data_q <= rd_rsp_data_i & elem_mask(size_q);
        end
    end

    vld_loop_idx #(.CNT_W(CNT_W), .LANE_W(LANE_W)) u_idx (
        .clk     (clk),
        .rst_n   (rst_n),
        .load_i  (accept),
        .step_i  (step),
        .rpt_i   (rpt),
        .selem_i (nelem_i),
        .lanes_i (lanes_per_reg(esize_i, qfull_i)),
        .rep_o   (rep),
        .elem_o  (elem),
        .lane_o  (lane),
        .last_o  (last)
    );

    vld_addr_gen #(.ADDR_W(ADDR_W)) u_addr (
        .clk    (clk),
        .rst_n  (rst_n),
        .load_i (accept),
        .base_i (base_addr_i),
        .size_i (esize_i),
        .step_i (step),
        .addr_o (addr)
    );

    // outputs
    always_comb begin
        busy_o         = (state_q != ST_IDLE);
        rd_req_valid_o = (state_q == ST_REQ);
        wr_en_o        = (state_q == ST_WRITE);
        done_o         = (state_q == ST_DONE);
        rd_addr_o      = addr;
        rd_size_o      = size_q;
        wr_reg_o       = first_q + REG_W'(rep) + REG_W'(elem);
        wr_lane_o      = lane;
        wr_size_o      = size_q;
        wr_data_o      = data_q;
        wr_clr_hi_o    = !full_q;
    end

    // checker state: last accepted address of this operation
    logic [ADDR_W-1:0] chk_prev_addr;
    logic              chk_have_prev;
    logic              chk_hs;
    assign chk_hs = rd_req_valid_o && rd_req_ready_i;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            chk_prev_addr <= '0;
            chk_have_prev <= 1'b0;
        end else if (accept) begin
            chk_have_prev <= 1'b0;
        end else if (chk_hs) begin
            chk_prev_addr <= rd_addr_o;
            chk_have_prev <= 1'b1;
        end
    end

    a_r5_addr_step: assert property (@(posedge clk) disable iff (!rst_n)
        chk_hs && chk_have_prev |-> rd_addr_o == chk_prev_addr + (ADDR_W'(1) << rd_size_o));

    a_r10_req_hold: assert property (@(posedge clk) disable iff (!rst_n)
        rd_req_valid_o && !rd_req_ready_i |=> rd_req_valid_o && $stable(rd_addr_o));

    a_r12_write_after_rsp: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en_o |-> $past(rd_rsp_valid_i));

    a_r9_done_after_write: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> $past(wr_en_o) && !wr_en_o);

    a_r8_size_hold: assert property (@(posedge clk) disable iff (!rst_n)
        busy_o && !done_o |=> $stable(wr_size_o) && $stable(wr_clr_hi_o));
endmodule

// File: tb/vstruct_ld_seq_bench.sv
module vstruct_ld_seq_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start_i = 1'b0;
    logic [31:0] base_addr_i = '0;
    logic [1:0]  esize_i = '0;
    logic        qfull_i = 1'b0;
    logic [4:0]  first_reg_i = '0;
    logic [2:0]  nelem_i = 3'd1;
    logic [2:0]  nregs_i = 3'd1;
    logic        busy_o, rd_req_valid_o, wr_en_o, wr_clr_hi_o, done_o;
    logic        rd_req_ready_i = 1'b0;
    logic        rd_rsp_valid_i = 1'b0;
    logic [63:0] rd_rsp_data_i = '0;
    logic [31:0] rd_addr_o;
    logic [1:0]  rd_size_o, wr_size_o;
    logic [4:0]  wr_reg_o;
    logic [3:0]  wr_lane_o;
    logic [63:0] wr_data_o;

    always #4 clk = ~clk;

    vstruct_ld_seq u_vstruct_ld_seq (.*);

    typedef struct packed {
        logic [4:0]  r;
        logic [3:0]  l;
        logic [63:0] d;
        logic [1:0]  s;
        logic        c;
    } wr_t;

    logic [31:0] exp_addr[$];
    wr_t         exp_wr[$];
    int          checks = 0;
    int          errors = 0;
    bit          mon_on = 1'b0;
    bit          stall_mode = 1'b0;
    bit          last_wr_prev = 1'b0;
    bit          prev_stall = 1'b0;
    logic [31:0] prev_addr = '0;
    logic [31:0] pend_addr = '0;
    int          pend = 0;
    int          cyc = 0;
    string       reg_tag = "R3";

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    function automatic logic [7:0] mem_byte(input logic [31:0] a);
        return 8'((a * 37) + (a >> 8) * 11 + 5);
    endfunction

    function automatic logic [63:0] mem_word(input logic [31:0] a);
        logic [63:0] v;
        for (int b = 0; b < 8; b++) v[b*8 +: 8] = mem_byte(a + 32'(b));
        return v;
    endfunction

    // expected stream built from the loop order in R3
    task automatic expect_load(input logic [31:0] base, input int sz, input bit q,
                               input int first, input int n, input int m);
        int rpt, lanes, bytes;
        logic [31:0] a;
        logic [63:0] mask;
        wr_t w;
        rpt   = (n == m) ? 1 : m;
        lanes = (8 >> sz) * (q ? 2 : 1);
        bytes = 1 << sz;
        mask  = (sz == 3) ? '1 : ((64'd1 << (8 * bytes)) - 64'd1);
        a = base;
        for (int i = 0; i < rpt; i++)
            for (int j = 0; j < lanes; j++)
                for (int k = 0; k < n; k++) begin
                    exp_addr.push_back(a);
                    w.r = 5'((first + i + k) % 32);
                    w.l = 4'(j);
                    w.d = mem_word(a) & mask;
                    w.s = 2'(sz);
                    w.c = !q;
                    exp_wr.push_back(w);
                    a = a + 32'(bytes);
                end
    endtask

    // memory port driver and per-cycle comparison
    always @(negedge clk) begin
        cyc++;
        rd_req_ready_i = stall_mode ? ((cyc % 4) != 1) : 1'b1;
        rd_rsp_valid_i = 1'b0;
        if (pend > 0) begin
            pend--;
            if (pend == 0) begin
                rd_rsp_valid_i = 1'b1;
                rd_rsp_data_i  = mem_word(pend_addr);
            end
        end
        if (mon_on) begin
            if (prev_stall) begin
                chk(rd_req_valid_o == 1'b1, "R10", "request dropped", 64'(rd_req_valid_o), 64'd1);
                chk(rd_addr_o == prev_addr, "R10", "address moved", 64'(rd_addr_o), 64'(prev_addr));
            end
            prev_stall = rd_req_valid_o && !rd_req_ready_i;
            prev_addr  = rd_addr_o;
            if (rd_req_valid_o && rd_req_ready_i) begin
                pend_addr = rd_addr_o;
                pend = 1 + (cyc % 3);
                if (exp_addr.size() == 0) chk(1'b0, "R5/R8", "extra request", 64'(rd_addr_o), 64'd0);
                else begin
                    logic [31:0] ea;
                    ea = exp_addr.pop_front();
                    chk(rd_addr_o == ea, "R5", "read address", 64'(rd_addr_o), 64'(ea));
                end
            end
            chk(done_o == last_wr_prev, "R9", "done pulse", 64'(done_o), 64'(last_wr_prev));
            last_wr_prev = 1'b0;
            if (wr_en_o) begin
                if (exp_wr.size() == 0) chk(1'b0, "R12/R8", "extra write", 64'(wr_reg_o), 64'd0);
                else begin
                    wr_t w;
                    w = exp_wr.pop_front();
                    chk(wr_reg_o == w.r, reg_tag, "register", 64'(wr_reg_o), 64'(w.r));
                    chk(wr_lane_o == w.l, "R2/R3", "lane", 64'(wr_lane_o), 64'(w.l));
                    chk(wr_data_o == w.d, "R1", "data", wr_data_o, w.d);
                    chk(wr_size_o == w.s, "R1", "size", 64'(wr_size_o), 64'(w.s));
                    chk(wr_clr_hi_o == w.c, "R7", "clear upper", 64'(wr_clr_hi_o), 64'(w.c));
                    last_wr_prev = (exp_wr.size() == 0);
                end
            end
        end
    end

    task automatic run_op(input logic [31:0] base, input int sz, input bit q,
                          input int first, input int n, input int m,
                          input bit stall, input bit poke, input string tag);
        int wd;
        bit seen;
        reg_tag = tag;
        expect_load(base, sz, q, first, n, m);
        @(negedge clk);
        stall_mode  = stall;
        start_i     = 1'b1;
        base_addr_i = base;
        esize_i     = 2'(sz);
        qfull_i     = q;
        first_reg_i = 5'(first);
        nelem_i     = 3'(n);
        nregs_i     = 3'(m);
        @(negedge clk);
        start_i = 1'b0;
        if (poke) begin
            // R8: start with different fields during the operation
            repeat (7) @(negedge clk);
            start_i = 1'b1; base_addr_i = 32'hDEAD_0000; esize_i = 2'd0;
            qfull_i = !q; first_reg_i = 5'd17; nelem_i = 3'd4; nregs_i = 3'd4;
            @(negedge clk);
            start_i = 1'b0;
        end
        seen = 1'b0;
        wd = 0;
        while (!seen && wd < 3000) begin
            @(negedge clk);
            #1;
            seen = done_o;
            wd++;
        end
        if (!seen) chk(1'b0, "R9", "watchdog, no done", 64'(wd), 64'd0);
        repeat (6) @(negedge clk);
        #1;
        chk(busy_o == 1'b0, "R8/R9", "busy after done", 64'(busy_o), 64'd0);
        chk(exp_wr.size() == 0, "R3", "writes missing", 64'(exp_wr.size()), 64'd0);
        exp_wr.delete();
        exp_addr.delete();
    endtask

    initial begin
        repeat (3) @(negedge clk);
        #1;
        chk(busy_o == 1'b0 && rd_req_valid_o == 1'b0 && wr_en_o == 1'b0 && done_o == 1'b0,
            "R11", "reset outputs", 64'({busy_o, rd_req_valid_o, wr_en_o, done_o}), 64'd0);
        rst_n = 1'b1;
        @(negedge clk);
        mon_on = 1'b1;
        run_op(32'h0000_1000, 0, 1'b1,  3, 1, 1, 1'b0, 1'b0, "R3");
        run_op(32'h0000_2007, 1, 1'b0, 10, 2, 2, 1'b1, 1'b0, "R4");
        run_op(32'h0000_3100, 2, 1'b1, 30, 3, 3, 1'b0, 1'b0, "R6");
        run_op(32'h0000_4000, 0, 1'b1,  0, 4, 4, 1'b1, 1'b0, "R4");
        run_op(32'h0000_5008, 3, 1'b0,  5, 1, 3, 1'b0, 1'b0, "R4");
        run_op(32'h0000_6010, 3, 1'b1, 29, 1, 4, 1'b1, 1'b0, "R6");
        run_op(32'h0000_7004, 2, 1'b0, 12, 1, 2, 1'b1, 1'b1, "R8");
        run_op(32'h0000_8001, 1, 1'b1, 31, 2, 2, 1'b0, 1'b0, "R6");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule